// File: doc/BRIEF.md
# Panel Status Byte Command Parser

This block sits behind a serial link's receive FIFO on a control-panel device and turns the incoming byte stream into framed commands. Each byte arrives with a one-cycle valid. A byte whose top bit is set opens a new command. The parser discards that byte's end-mark flag and compares the embedded three-bit address field with the panel's own address. It also recognises the address-allocation status, which is accepted whatever the address. It then latches a three-bit command code.

Bytes whose top bit is clear are payload for the latched command. For the event, parameter and other commands, every payload byte leaves the block as a one-cycle strobe. The strobe carries the full command code, the seven payload bits and the position of the byte within the command. The downstream handler can therefore read an event's size, identifier and data words by index without tracking framing. Payload that arrives under the dummy command, under an unrecognised code or after a cancelled command produces nothing, and it clears the latched state.

Top module: `panel_cmd_parser`

## Requirements
- R1: After reset no command is latched: `out_strobe` is low, and data bytes (bit 7 clear) produce no strobe until a matching status byte arrives.
- R2: A status byte whose bits 5..3 equal `own_id` and whose bits 2..0 are 100 (event), 101 (parameter) or 110 (other) latches that command. Each following data byte produces exactly one `out_strobe` pulse. The pulse comes in the cycle after the byte is accepted and carries `out_cmd` = 0x84, 0x85 or 0x86, `out_data` = byte bits 6..0, and `out_index` starting at 0.
- R3: Bit 6 of a status byte (the end-mark flag) has no effect on matching or on the latched command.
- R4: A status byte that is not the allocation code and whose bits 5..3 differ from `own_id` cancels any latched command, so later data bytes produce no strobe.
- R5: A status byte equal to 0xBE or 0xFE latches the other command (0x86) whatever the value of `own_id`.
- R6: Every accepted status byte restarts the data index at 0.
- R7: A data byte that arrives while the latched code is dummy (111) or an unrecognised code (000 to 011) produces no strobe and clears both the latched command and the index.
- R8: A byte is taken only when `in_valid` is high. Cycles with `in_valid` low leave the latched command and the index unchanged and produce no strobe.
- R9: Back-to-back data bytes of one command each produce a strobe on consecutive cycles, and the index rises by one per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte present on `in_byte` this cycle |
| in_byte | input | 8 | Received byte |
| own_id | input | 3 | Address of this panel (normally 111) |
| out_strobe | output | 1 | One-cycle pulse per forwarded data byte |
| out_cmd | output | 8 | Command code of the forwarded byte (0x84/0x85/0x86) |
| out_data | output | 7 | Seven payload bits of the forwarded byte |
| out_index | output | IDX_W | Position of the byte within its command, from 0 |

## Verification
The bench aims at the cases where framing state goes wrong. A status byte carrying the end-mark flag would be lost by a parser that compared it unmasked. A foreign-address status would leave an old command live if it did not cancel. The allocation code would be dropped when `own_id` is not 111 if it were matched as an ordinary address. A repeated status would leave indices running on if it did not restart the count. Dummy and low codes would produce stray strobes if they were treated as served. Idle gaps and back-to-back runs expose a counter that advances on invalid cycles or skips values.

// File: rtl/pcp_pkg.sv
// Shared constants for the panel command parser.
// Assumes 8-bit link bytes, with bit 7 marking a status byte.
package pcp_pkg;
    localparam logic [7:0] STATUS_FLAG = 8'h80;
    localparam logic [7:0] ENDMARK_BIT = 8'h40;
    localparam logic [7:0] ALLOC_CODE  = 8'hBE;
    localparam logic [2:0] CODE_EVENT  = 3'd4;
    localparam logic [2:0] CODE_PARAM  = 3'd5;
    localparam logic [2:0] CODE_OTHER  = 3'd6;
    localparam logic [2:0] CODE_DUMMY  = 3'd7;

    // True for the codes whose payload is forwarded
    function automatic logic code_served(input logic [2:0] code);
        return (code == CODE_EVENT) || (code == CODE_PARAM) || (code == CODE_OTHER);
    endfunction
endpackage

// File: rtl/pcp_status_decode.sv
// Classifies one received byte.
// A status byte is a hit when it is the allocation code (end mark ignored)
// or when its address field matches own_id_i. Purely combinational.
module pcp_status_decode
    import pcp_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic [2:0] own_id_i,
    output logic       is_status_o,
    output logic       hit_o,
    output logic [2:0] code_o
);
    logic [7:0] masked;
    logic       is_alloc;
    logic       id_match;

    // Strip the end mark, then compare against the allocation code and the address
    always_comb begin
        masked      = byte_i & ~ENDMARK_BIT;
        is_status_o = (byte_i & STATUS_FLAG) != 8'h00;
        is_alloc    = masked == ALLOC_CODE;
        id_match    = masked[5:3] == own_id_i;
        hit_o       = is_status_o && (is_alloc || id_match);
        code_o      = is_alloc ? CODE_OTHER : masked[2:0];
    end
endmodule

// File: rtl/pcp_cmd_state.sv
// Holds the latched command and the data index.
// Assumes the inputs come from pcp_status_decode for the byte currently on the link.
// fire_o marks a data byte that is to be forwarded this cycle.
module pcp_cmd_state
    import pcp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             is_status_i,
    input  logic             hit_i,
    input  logic [2:0]       code_i,
    output logic             active_o,
    output logic [2:0]       code_o,
    output logic [IDX_W-1:0] index_o,
    output logic             fire_o
);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    // Forward a data byte only under a latched, served command
    always_comb fire_o = valid_i && !is_status_i && active_o && code_served(code_o);

    // Latch or cancel on status bytes, count or clear on data bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            code_o   <= '0;
            index_o  <= '0;
        end else if (valid_i) begin
            if (is_status_i) begin
                index_o  <= '0;
                active_o <= hit_i;
                code_o   <= hit_i ? code_i : 3'd0;
            end else if (fire_o) begin
                index_o  <= index_o + IDX_ONE;
            end else begin
                active_o <= 1'b0;
                code_o   <= '0;
                index_o  <= '0;
            end
        end
    end

    AST_STATUS_RESTARTS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_status_i) |=> (index_o == '0)); // R6
    AST_MISMATCH_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_status_i && !hit_i) |=> !active_o); // R4
    AST_UNSERVED_DATA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !is_status_i && !fire_o) |=> (!active_o && index_o == '0)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(active_o) && $stable(code_o) && $stable(index_o))); // R8
endmodule

// File: rtl/panel_cmd_parser.sv
// Top of the panel command parser.
// Decodes each valid byte, updates the framing state and registers one
// output strobe per forwarded data byte, one cycle after acceptance.
module panel_cmd_parser
    import pcp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic [2:0]       own_id,
    output logic             out_strobe,
    output logic [7:0]       out_cmd,
    output logic [6:0]       out_data,
    output logic [IDX_W-1:0] out_index
);
    logic             dec_status;
    logic             dec_hit;
    logic [2:0]       dec_code;
    logic             st_active;
    logic [2:0]       st_code;
    logic [IDX_W-1:0] st_index;
    logic             st_fire;

    pcp_status_decode u_decode (
        .byte_i      (in_byte),
        .own_id_i    (own_id),
        .is_status_o (dec_status),
        .hit_o       (dec_hit),
        .code_o      (dec_code)
    );

    pcp_cmd_state #(.IDX_W(IDX_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (in_valid),
        .is_status_i (dec_status),
        .hit_i       (dec_hit),
        .code_i      (dec_code),
        .active_o    (st_active),
        .code_o      (st_code),
        .index_o     (st_index),
        .fire_o      (st_fire)
    );

    // Register the forwarded byte with its command and position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_strobe <= 1'b0;
            out_cmd    <= '0;
            out_data   <= '0;
            out_index  <= '0;
        end else begin
            out_strobe <= st_fire;
            if (st_fire) begin
                out_cmd   <= {5'b10000, st_code};
                out_data  <= in_byte[6:0];
                out_index <= st_index;
            end
        end
    end

    AST_STROBE_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> ($past(in_valid) && !$past(in_byte[7]))); // R8
    AST_STROBE_CMD_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> (out_cmd == 8'h84 || out_cmd == 8'h85 || out_cmd == 8'h86)); // R2
    AST_STROBE_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> (out_data == $past(in_byte[6:0]))); // R2
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_strobe); // R8
    AST_ACTIVE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        st_fire |-> st_active); // R7
endmodule

// File: tb/panel_cmd_parser_tb.sv
module panel_cmd_parser_tb;
    localparam int IDX_W = 8;

    typedef struct {
        logic [7:0] cmd;
        logic [6:0] data;
        int         idx;
        string      tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic [2:0]       own_id = 3'b111;
    logic             out_strobe;
    logic [7:0]       out_cmd;
    logic [6:0]       out_data;
    logic [IDX_W-1:0] out_index;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   done = 1'b0;
    logic [7:0] cur_cmd = 8'h00;
    int         cur_idx = 0;

    always #5 clk = ~clk;

    panel_cmd_parser #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .own_id(own_id), .out_strobe(out_strobe), .out_cmd(out_cmd),
        .out_data(out_data), .out_index(out_index)
    );

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 20000", cycles);
            report();
        end
    end

    // Monitor: compare every strobe against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_strobe) begin
            checks = checks + 1;
            if (q.size() == 0) begin
                errors = errors + 1;
                $display("FAIL unexpected strobe: actual cmd=%h data=%h idx=%0d, expected none",
                         out_cmd, out_data, out_index);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (out_cmd !== e.cmd || out_data !== e.data || int'(out_index) != e.idx) begin
                    errors = errors + 1;
                    $display("FAIL %s: actual cmd=%h data=%h idx=%0d, expected cmd=%h data=%h idx=%0d",
                             e.tag, out_cmd, out_data, out_index, e.cmd, e.data, e.idx);
                end
            end
        end
    end

    // Driver: one byte for one cycle; expected items come from the requirements
    task automatic send_status(input logic [7:0] b, input logic [7:0] expect_cmd);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        cur_cmd  = expect_cmd;
        cur_idx  = 0;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_data(input logic [6:0] d, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = {1'b0, d};
        if (cur_cmd != 8'h00) begin
            q.push_back('{cmd: cur_cmd, data: d, idx: cur_idx, tag: tag});
            cur_idx = cur_idx + 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_run(input logic [6:0] first, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = {1'b0, first + 7'(i)};
            q.push_back('{cmd: cur_cmd, data: first + 7'(i), idx: cur_idx, tag: tag});
            cur_idx = cur_idx + 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drained(input string tag);
        repeat (3) @(negedge clk);
        checks = checks + 1;
        if (q.size() != 0) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d strobes missing, expected 0", tag, q.size());
            q.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks = checks + 1;
        if (out_strobe !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1: actual strobe=%b, expected 0", out_strobe);
        end
        // R1: data with nothing latched is dropped
        send_data(7'h05, "R1");
        send_data(7'h06, "R1");
        drained("R1");

        // R2: event, parameter, other under own address 111
        send_status(8'hBC, 8'h84);
        send_data(7'h03, "R2 event size");
        send_data(7'h10, "R2 event id");
        send_data(7'h7F, "R2 event word");
        send_status(8'hBD, 8'h85);
        send_data(7'h22, "R2 param");
        send_data(7'h33, "R2 param");
        send_status(8'hBE, 8'h86);
        send_data(7'h01, "R2 other");
        drained("R2");

        // R3: end-mark flag set on the status byte
        send_status(8'hFD, 8'h85);
        send_data(7'h11, "R3 endmark param");
        send_status(8'hFC, 8'h84);
        send_data(7'h12, "R3 endmark event");
        drained("R3");

        // R4: foreign address cancels the running command
        send_status(8'hBC, 8'h84);
        send_data(7'h01, "R4 before cancel");
        send_status(8'h94, 8'h00);
        send_data(7'h02, "R4");
        send_data(7'h03, "R4");
        drained("R4");

        // R5: allocation code accepted with a different own address
        own_id = 3'b010;
        send_status(8'hFE, 8'h86);
        send_data(7'h44, "R5 alloc");
        send_status(8'h94, 8'h84);
        send_data(7'h45, "R5 own 010");
        send_status(8'hBC, 8'h00);
        send_data(7'h46, "R5 old address now foreign");
        drained("R5");
        own_id = 3'b111;

        // R6: repeated status restarts the index
        send_status(8'hBD, 8'h85);
        send_data(7'h01, "R6");
        send_data(7'h02, "R6");
        send_status(8'hBD, 8'h85);
        send_data(7'h03, "R6 restarted");
        drained("R6");

        // R7: dummy and unrecognised codes
        send_status(8'hBF, 8'h00);
        send_data(7'h05, "R7 dummy");
        send_status(8'hB8, 8'h00);
        send_data(7'h06, "R7 code 000");
        send_status(8'hBB, 8'h00);
        send_data(7'h07, "R7 code 011");
        send_status(8'hBC, 8'h84);
        send_data(7'h08, "R7 served after dummy");
        drained("R7");

        // R8: invalid cycles with data on the bus do nothing
        send_status(8'hBC, 8'h84);
        send_data(7'h21, "R8");
        @(negedge clk);
        in_byte = 8'h55;
        repeat (5) @(negedge clk);
        in_byte = 8'h00;
        send_data(7'h22, "R8 index held");
        drained("R8");

        // R9: back-to-back run
        send_status(8'hBE, 8'h86);
        send_run(7'h30, 20, "R9 back-to-back");
        drained("R9");

        done = 1'b1;
        report();
    end
endmodule